// File: doc/BRIEF.md
# Filter Compute Microsequencer

A small program sequencer that drives a time-shared filter compute engine. A host fills a 32-step program store with 21-bit words. The sequencer runs one step per clock. Each word is one of three kinds. A conditional wait stalls until its test passes. A filter operation may dispatch work to the engine and may also update the loop and wait counters. A conditional jump branches on its test.

The engine itself is outside this block. It sees a one-cycle start pulse that carries a type code, a step count, a rotation index and a resampler-increment request. It answers with a done pulse. The sequencer holds at a dispatching step until that done arrives. Conditions come from four sources: a 10-bit wait counter compared against a threshold, a 12-bit loop counter, a resampler carry input, and a sync input that can be swapped for a host flag.

Top module: `filter_microseq`

## Requirements
- R1: After reset, pc_o, loop_cnt_o, wait_cnt_o and eng_rot_o are 0 and eng_start_o is low.
- R2: Word bits 8:7 = 00 is a wait. Word bits 2:0 are its condition code and bits 6:3 are ignored. The step advances by one when the condition holds and otherwise stays put.
- R3: Word bit 8 = 1 is a jump, with destination in bits 7:3 and condition in bits 2:0. The step becomes the destination when the condition holds and otherwise advances by one. Step 31 advances to step 0.
- R4: Condition codes: 0 wait count < threshold; 1 wait count >= threshold; 2 loop count != 0; 3 loop count == 0; 4 rs_carry_i low; 5 rs_carry_i high; 6 sync_i if sync_en_i else host_flag_i; 7 always.
- R5: Word bits 8:7 = 01 is a filter operation with control bits 6..0 = start, resampler increment, decrement select, wait decrement, loop load, loop decrement, rotation enable. With start set, eng_start_o is high for exactly the first cycle at that step. That cycle carries eng_type_o = bits 14:9 and eng_steps_o = bits 17:15. The step then holds until eng_done_i and advances on the next edge. With start clear, the step advances at once.
- R6: Loop load (bit 2) loads the loop counter from word bits 20:9. Loop decrement (bit 1) subtracts one, stopping at 0. If both bits are set, the load wins.
- R7: Wait decrement (bit 3) subtracts wc_dec_a_i when bit 4 is 0 and wc_dec_b_i when bit 4 is 1. The result saturates at 0.
- R8: wc_load_i reloads the wait counter and overrides everything else. sample_inc_i adds one, saturating at 1023. When it coincides with a decrement, the increment is applied first.
- R9: eng_rot_o gives the rotation index (0:1, 1:j, 2:-1, 3:-j) during a start. The index advances by one, modulo 4, only after a start whose rotation bit (bit 0) is set.
- R10: rs_incr_o pulses with eng_start_o when word bit 5 is set.
- R11: While run_i is low, the step is forced to 0, no start is issued and no counter side effect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Sequencer enable |
| prog_we_i | input | 1 | Program store write strobe |
| prog_addr_i | input | 5 | Program store write address |
| prog_data_i | input | 21 | Program word |
| wc_thresh_i | input | 10 | Wait count threshold |
| wc_dec_a_i | input | 10 | Wait decrement, select 0 |
| wc_dec_b_i | input | 10 | Wait decrement, select 1 |
| wc_load_i | input | 1 | Wait counter reload strobe |
| wc_load_val_i | input | 10 | Wait counter reload value |
| sample_inc_i | input | 1 | Sample arrival, wait count +1 |
| rs_carry_i | input | 1 | Resampler carry |
| sync_en_i | input | 1 | Use sync_i for condition 6 |
| sync_i | input | 1 | External sync |
| host_flag_i | input | 1 | Host-controlled condition bit |
| eng_done_i | input | 1 | Engine finished |
| eng_start_o | output | 1 | Engine start pulse |
| eng_type_o | output | 6 | Filter type code |
| eng_steps_o | output | 3 | Steps per filter minus one |
| eng_rot_o | output | 2 | Rotation index |
| rs_incr_o | output | 1 | Resampler increment request |
| pc_o | output | 5 | Current step |
| loop_cnt_o | output | 12 | Loop counter |
| wait_cnt_o | output | 10 | Wait counter |

## Verification
The assertions assume the program store is only written while run_i is low, so the word under execution never changes during a step. They also assume eng_done_i is meaningful only in the busy state, and done pulses arriving in other cycles are treated as don't-care. The bench rewrites the program with run_i low each time, and it holds eng_done_i high through whole runs to show that a done seen outside the busy state has no effect. The condition sweep pairs every code with sixteen input patterns around the threshold edge and around loop count zero.

// File: rtl/fmseq_pkg.sv
package fmseq_pkg;
  localparam int IW     = 21;
  localparam int DEST_W = 5;
  localparam int DEPTH  = 2 ** DEST_W;
  localparam int TYPE_W = 6;
  localparam int STEP_W = 3;
  localparam int LOOP_W = 12;
  localparam int WC_W   = 10;

  typedef enum logic [1:0] {K_WAIT, K_FILT, K_JUMP} kind_e;

  typedef struct packed {
    logic start;
    logic rs_inc;
    logic dsel;
    logic den;
    logic ld_lp;
    logic dec_lp;
    logic rot_en;
  } fctl_t;

  typedef enum logic [2:0] {
    C_WC_LO, C_WC_HI, C_LP_NZ, C_LP_Z, C_RC_LO, C_RC_HI, C_SYNC, C_ALWAYS
  } cond_e;

  function automatic kind_e kind_of(logic [1:0] hi);
    if (hi[1])      return K_JUMP;
    else if (hi[0]) return K_FILT;
    else            return K_WAIT;
  endfunction
endpackage

// File: rtl/fms_cond.sv
module fms_cond
  import fmseq_pkg::*;
(
  input  logic [2:0]        cc_i,
  input  logic [WC_W-1:0]   wc_i,
  input  logic [WC_W-1:0]   thr_i,
  input  logic [LOOP_W-1:0] lp_i,
  input  logic              carry_i,
  input  logic              sync_en_i,
  input  logic              sync_i,
  input  logic              host_i,
  output logic              hit_o
);
  logic wc_ge;
  logic lp_z;
  assign wc_ge = (wc_i >= thr_i);
  assign lp_z  = (lp_i == '0);

  always_comb begin
    unique case (cond_e'(cc_i))
      C_WC_LO:  hit_o = !wc_ge;
      C_WC_HI:  hit_o = wc_ge;
      C_LP_NZ:  hit_o = !lp_z;
      C_LP_Z:   hit_o = lp_z;
      C_RC_LO:  hit_o = !carry_i;
      C_RC_HI:  hit_o = carry_i;
      C_SYNC:   hit_o = sync_en_i ? sync_i : host_i;
      default:  hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fms_wait_ctr.sv
module fms_wait_ctr #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic [W-1:0] dec_amt_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q, bumped, cnt_d;

  always_comb begin
    bumped = (inc_i && cnt_q != MAX) ? cnt_q + 1'b1 : cnt_q;
    if (ld_i)       cnt_d = ld_val_i;
    else if (dec_i) cnt_d = (bumped >= dec_amt_i) ? bumped - dec_amt_i : '0;
    else            cnt_d = bumped;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  p_wc_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !ld_i && !inc_i) |=> (cnt_q <= $past(cnt_q)));
  p_wc_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i)));
  p_wc_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !ld_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/fms_loop_ctr.sv
module fms_loop_ctr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    cnt_q <= '0;
    else if (ld_i)                  cnt_q <= ld_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign cnt_o = cnt_q;

  p_lp_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i)));
  p_lp_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fms_rot.sv
module fms_rot (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  output logic [1:0] rot_o
);
  logic [1:0] rot_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     rot_q <= 2'd0;
    else if (step_i) rot_q <= rot_q + 2'd1;

  assign rot_o = rot_q;

  p_rot_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (rot_q == 2'($past(rot_q) + 2'd1)));
  p_rot_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(rot_q));
endmodule

// File: rtl/filter_microseq.sv
module filter_microseq
  import fmseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              prog_we_i,
  input  logic [DEST_W-1:0] prog_addr_i,
  input  logic [IW-1:0]     prog_data_i,
  input  logic [WC_W-1:0]   wc_thresh_i,
  input  logic [WC_W-1:0]   wc_dec_a_i,
  input  logic [WC_W-1:0]   wc_dec_b_i,
  input  logic              wc_load_i,
  input  logic [WC_W-1:0]   wc_load_val_i,
  input  logic              sample_inc_i,
  input  logic              rs_carry_i,
  input  logic              sync_en_i,
  input  logic              sync_i,
  input  logic              host_flag_i,
  input  logic              eng_done_i,
  output logic              eng_start_o,
  output logic [TYPE_W-1:0] eng_type_o,
  output logic [STEP_W-1:0] eng_steps_o,
  output logic [1:0]        eng_rot_o,
  output logic              rs_incr_o,
  output logic [DEST_W-1:0] pc_o,
  output logic [LOOP_W-1:0] loop_cnt_o,
  output logic [WC_W-1:0]   wait_cnt_o
);
  typedef enum logic {S_EXEC, S_BUSY} state_e;

  logic [IW-1:0]     mem_q [DEPTH];
  logic [DEST_W-1:0] pc_q, pc_d, pc_inc;
  state_e            state_q, state_d;
  logic [IW-1:0]     inst;
  kind_e             kind;
  fctl_t             fctl;
  logic [DEST_W-1:0] dest;
  logic              hit, exec, fire_filt, start;
  logic [LOOP_W-1:0] lp_cnt;
  logic [WC_W-1:0]   wc_cnt;

  // program store
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (prog_we_i) begin
      mem_q[prog_addr_i] <= prog_data_i;
    end

  assign inst      = mem_q[pc_q];
  assign kind      = kind_of(inst[8:7]);
  assign fctl      = fctl_t'(inst[6:0]);
  assign dest      = inst[3 +: DEST_W];
  assign pc_inc    = pc_q + 1'b1;
  assign exec      = run_i && (state_q == S_EXEC);
  assign fire_filt = exec && (kind == K_FILT);
  assign start     = fire_filt && fctl.start;

  fms_cond u_cond (
    .cc_i      (inst[2:0]),
    .wc_i      (wc_cnt),
    .thr_i     (wc_thresh_i),
    .lp_i      (lp_cnt),
    .carry_i   (rs_carry_i),
    .sync_en_i (sync_en_i),
    .sync_i    (sync_i),
    .host_i    (host_flag_i),
    .hit_o     (hit)
  );

  always_comb begin
    pc_d    = pc_q;
    state_d = state_q;
    if (!run_i) begin
      pc_d    = '0;
      state_d = S_EXEC;
    end else if (state_q == S_BUSY) begin
      if (eng_done_i) begin
        pc_d    = pc_inc;
        state_d = S_EXEC;
      end
    end else begin
      unique case (kind)
        K_WAIT: if (hit) pc_d = pc_inc;
        K_JUMP: pc_d = hit ? dest : pc_inc;
        default: begin
          if (fctl.start) state_d = S_BUSY;
          else            pc_d    = pc_inc;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pc_q    <= '0;
      state_q <= S_EXEC;
    end else begin
      pc_q    <= pc_d;
      state_q <= state_d;
    end

  fms_loop_ctr #(.W(LOOP_W)) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (fire_filt && fctl.ld_lp),
    .ld_val_i (inst[IW-1:9]),
    .dec_i    (fire_filt && fctl.dec_lp),
    .cnt_o    (lp_cnt)
  );

  fms_wait_ctr #(.W(WC_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (wc_load_i),
    .ld_val_i  (wc_load_val_i),
    .inc_i     (sample_inc_i),
    .dec_i     (fire_filt && fctl.den),
    .dec_amt_i (fctl.dsel ? wc_dec_b_i : wc_dec_a_i),
    .cnt_o     (wc_cnt)
  );

  fms_rot u_rot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (start && fctl.rot_en),
    .rot_o  (eng_rot_o)
  );

  assign eng_start_o = start;
  assign eng_type_o  = inst[9 +: TYPE_W];
  assign eng_steps_o = inst[15 +: STEP_W];
  assign rs_incr_o   = start && fctl.rs_inc;
  assign pc_o        = pc_q;
  assign loop_cnt_o  = lp_cnt;
  assign wait_cnt_o  = wc_cnt;

  p_start_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  p_busy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state_q == S_BUSY && !eng_done_i) |=> (pc_q == $past(pc_q)));
  p_wait_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && kind == K_WAIT && !hit) |=> (pc_q == $past(pc_q)));
  p_jump_taken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && kind == K_JUMP && hit) |=> (pc_q == $past(dest)));
  p_run_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pc_q == '0 && state_q == S_EXEC));
  p_rs_with_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_incr_o |-> eng_start_o);
endmodule

// File: tb/sim_filter_microseq.sv
module sim_filter_microseq;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic run_i = 0, prog_we_i = 0;
  logic [4:0] prog_addr_i = '0;
  logic [20:0] prog_data_i = '0;
  logic [9:0] wc_thresh_i = 10'd100, wc_dec_a_i = 10'd7, wc_dec_b_i = 10'd20;
  logic wc_load_i = 0;
  logic [9:0] wc_load_val_i = '0;
  logic sample_inc_i = 0, rs_carry_i = 0, sync_en_i = 0, sync_i = 0, host_flag_i = 0;
  logic eng_done_i = 0;
  logic eng_start_o, rs_incr_o;
  logic [5:0] eng_type_o;
  logic [2:0] eng_steps_o;
  logic [1:0] eng_rot_o;
  logic [4:0] pc_o;
  logic [11:0] loop_cnt_o;
  logic [9:0] wait_cnt_o;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  filter_microseq u0 (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [20:0] d);
    prog_we_i = 1; prog_addr_i = 5'(a); prog_data_i = d;
    step();
    prog_we_i = 0;
  endtask

  // filter word: bits 20:9 payload, 8:7 = 01, 6:0 control
  function automatic logic [20:0] w_filt(logic [6:0] ctl, logic [11:0] hi);
    return {hi, 2'b01, ctl};
  endfunction
  function automatic logic [20:0] w_jump(int dst, int cc);
    return {12'd0, 1'b1, 5'(dst), 3'(cc)};
  endfunction
  function automatic logic [20:0] w_wait(int cc);
    return {12'd0, 2'b00, 4'b1010, 3'(cc)};  // bits 6:3 junk, must be ignored
  endfunction

  function automatic bit cond_exp(int cc, int w, int t, int l, bit c, bit se, bit s, bit h);
    case (cc)
      0: return w < t;
      1: return w >= t;
      2: return l != 0;
      3: return l == 0;
      4: return !c;
      5: return c;
      6: return se ? s : h;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n0;
    #5 rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 pc", pc_o, 0);
    chk("R1 loop", loop_cnt_o, 0);
    chk("R1 wait", wait_cnt_o, 0);
    chk("R1 start", eng_start_o, 0);
    chk("R1 rot", eng_rot_o, 0);

    // R9/R10/R5: rotation with done held high
    wr(0, w_filt(7'b1100001, {3'd0, 3'd1, 6'h20}));
    wr(1, w_filt(7'b1000000, {3'd0, 3'd0, 6'h05}));
    wr(2, w_jump(0, 7));
    eng_done_i = 1; run_i = 1; #1;
    n0 = 0;
    for (int i = 0; i < 24; i++) begin
      if (eng_start_o) begin
        if (pc_o == 0) begin
          chk("R9 rot", eng_rot_o, n0 % 4);
          chk("R5 type", eng_type_o, 6'h20);
          chk("R5 steps", eng_steps_o, 1);
          chk("R10 rs", rs_incr_o, 1);
          n0++;
        end else begin
          chk("R9 rot no-en", eng_rot_o, n0 % 4);
          chk("R5 type", eng_type_o, 6'h05);
          chk("R10 rs off", rs_incr_o, 0);
        end
      end
      step();
    end
    chk("R9 starts seen", n0 > 4, 1);

    // R5 hold until done; R11 no start while run low
    run_i = 0; eng_done_i = 0;
    step();
    chk("R11 pc", pc_o, 0);
    chk("R11 no start", eng_start_o, 0);
    run_i = 1; #1;
    chk("R5 start", eng_start_o, 1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R5 hold pc", pc_o, 0);
      chk("R5 single pulse", eng_start_o, 0);
    end
    eng_done_i = 1;
    step();
    eng_done_i = 0;
    chk("R5 advance", pc_o, 1);
    run_i = 0; step();

    // R4 condition sweep via jump, R6 load via filter word
    for (int cc = 0; cc < 8; cc++) begin
      for (int k = 0; k < 16; k++) begin
        int w, l;
        bit c, se, s, h, e;
        w = 99 + (k % 3);
        l = ((k >> 1) & 1) ? 0 : 3;
        c = k[0]; se = k[2]; s = k[3]; h = k[1] ^ k[3];
        rs_carry_i = c; sync_en_i = se; sync_i = s; host_flag_i = h;
        wc_load_i = 1; wc_load_val_i = 10'(w);
        wr(0, w_filt(7'b0000100, 12'(l)));
        wc_load_i = 0;
        wr(1, w_jump(20, cc));
        run_i = 1;
        step(); step();
        e = cond_exp(cc, w, 100, l, c, se, s, h);
        chk("R4 cond", pc_o, e ? 20 : 2);
        run_i = 0; step();
      end
    end
    chk("R6 loop after sweep", loop_cnt_o, 0);

    // R2 wait stall on carry
    wr(0, w_wait(5));
    rs_carry_i = 0; run_i = 1;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R2 stall", pc_o, 0);
    end
    rs_carry_i = 1;
    step(); chk("R2 release", pc_o, 1);
    run_i = 0; rs_carry_i = 0; step();

    // R7/R8 wait counter
    wr(0, w_filt(7'b0001000, 12'd0));
    wr(1, w_filt(7'b0011000, 12'd0));
    wr(2, w_filt(7'b0011000, 12'd0));
    wr(3, w_filt(7'b0011000, 12'd0));
    wr(4, w_wait(1));
    wr(5, w_wait(6));
    sync_en_i = 0; host_flag_i = 0;
    wc_load_i = 1; wc_load_val_i = 10'd50; step(); wc_load_i = 0;
    run_i = 1;
    step(); chk("R7 dec a", wait_cnt_o, 43);
    step(); chk("R7 dec b", wait_cnt_o, 23);
    step(); chk("R7 dec b", wait_cnt_o, 3);
    step(); chk("R7 floor", wait_cnt_o, 0);
    step(); chk("R2 wait lo stall", pc_o, 4);
    sample_inc_i = 1; step(); sample_inc_i = 0;
    chk("R8 inc", wait_cnt_o, 1);
    chk("R2 still stalled", pc_o, 4);
    wc_load_i = 1; wc_load_val_i = 10'd1023; sample_inc_i = 1; step();
    wc_load_i = 0;
    chk("R8 load wins", wait_cnt_o, 1023);
    step(); sample_inc_i = 0;
    chk("R8 saturate", wait_cnt_o, 1023);
    chk("R4 wait hi released", pc_o, 5);
    run_i = 0; step();
    wc_load_i = 1; wc_load_val_i = 10'd10; step(); wc_load_i = 0;
    run_i = 1; sample_inc_i = 1; step(); sample_inc_i = 0;
    chk("R8 inc then dec", wait_cnt_o, 4);
    run_i = 0; step();
    chk("R11 no side effect", wait_cnt_o, 4);

    // R6 loop counter
    wr(0, w_filt(7'b0000100, 12'd3));
    wr(1, w_filt(7'b0000010, 12'd0));
    wr(2, w_jump(1, 2));
    wr(3, w_filt(7'b0000010, 12'd0));
    wr(4, w_wait(3));
    wr(5, w_wait(6));
    run_i = 1;
    step(); chk("R6 load", loop_cnt_o, 3);
    step(); chk("R6 dec", loop_cnt_o, 2);
    repeat (10) step();
    chk("R6 loop exit pc", pc_o, 5);
    chk("R6 floor", loop_cnt_o, 0);
    run_i = 0; step();
    wr(0, w_filt(7'b0000110, 12'd9));
    wr(1, w_wait(6));
    run_i = 1; step(); step();
    chk("R6 load wins", loop_cnt_o, 9);
    run_i = 0; step();

    // R3 wrap and jump to 31
    for (int a = 0; a < 32; a++) wr(a, w_wait(7));
    run_i = 1;
    repeat (33) step();
    chk("R3 wrap", pc_o, 1);
    run_i = 0; step();
    chk("R11 forced zero", pc_o, 0);
    wr(0, w_jump(31, 7));
    run_i = 1;
    step(); chk("R3 dest", pc_o, 31);
    step(); chk("R3 31 to 0", pc_o, 0);
    run_i = 0; step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule